// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Sequencer

This block is the device-side write engine of a byte-wide parallel nonvolatile memory, modelled in one synchronous clock domain. A host drives active-low select, write and output-enable strobes in the usual asynchronous style. The block resynchronises and deglitches those strobes, takes the address when a write cycle opens and the data when it closes, and gathers the bytes into a page buffer.

A burst of byte loads ends when no new write cycle opens for a configurable idle time. The block then enters one programming interval of fixed length. In that interval it copies every loaded byte into the backing array, under the page address of the first byte of the burst. Bytes of the page that were not loaded keep their old contents. A busy flag covers the whole span from the first load to the end of programming. While a burst is in flight, reading the last written address returns that byte with its top bit inverted, so the host can poll for completion.

Top module: `page_write_engine`

## Requirements
- R1: After reset, busy_o and prog_o are 0, and every array byte reads 8'hFF.
- R2: A read (cs_ni=0, oe_ni=0, we_ni=1) returns the array byte at addr_i on rdata_o one clock later. rdata_o is 0 whenever that strobe combination is absent.
- R3: If oe_ni is low when cs_ni and we_ni are both low, no write cycle opens, busy_o stays 0 and the array is unchanged.
- R4: A write cycle opens only when cs_ni and we_ni are both low. Either strobe low on its own opens nothing.
- R5: A joint low of cs_ni and we_ni that lasts fewer than FILT clock cycles opens no write.
- R6: busy_o rises after the first accepted write cycle opens, and it falls in the same cycle as prog_o at the end of programming.
- R7: Every newly opened write cycle restarts the load timer. Programming starts only after LOAD_CYC cycles with no write in progress, so bytes spaced closer than that join one page.
- R8: The commit page is the upper address bits (above bit PAGE_W-1) of the first byte of the burst. Each byte lands at its own low PAGE_W address bits within that page, and unloaded bytes of the page keep their value.
- R9: Write strobes that arrive while prog_o is high are ignored. They neither reach the array nor start a new burst.
- R10: While busy_o is high, a read of the raw address of the last loaded byte returns that byte with bit 7 inverted and bits 6:0 unchanged. Once idle, the read returns the true stored value.
- R11: prog_o stays high for exactly PROG_CYC cycles, whatever the number of loaded bytes.
- R12: The stored byte is the wdata_i value present when the write cycle closes (first of cs_ni/we_ni rising).
- R13: The byte address is the addr_i value present when the write cycle opens. A later change of addr_i within the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| busy_o | output | 1 | Burst loading or programming in progress |
| prog_o | output | 1 | Programming interval active |

## Verification
Strobe results are due after a fixed pipeline: two synchroniser flops, FILT filter cycles, and one register each in capture and sequencing. The bench therefore samples busy_o and the absence of writes only after 40 or more idle cycles. It measures the start of programming with a tolerance window around LOAD_CYC after the last strobe release. A read result is due one clock after the read strobes are applied, so the bench samples it three falling edges later. The length of the programming interval is counted edge by edge and must equal PROG_CYC exactly. Array contents are checked only once busy_o has fallen.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_e;

  localparam int unsigned STRB_CS = 0;
  localparam int unsigned STRB_WE = 1;
  localparam int unsigned STRB_OE = 2;
  localparam int unsigned N_STRB  = 3;
endpackage

// File: rtl/pw_deglitch.sv
module pw_deglitch #(
  parameter int unsigned FILT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);
  localparam int unsigned CW = (FILT < 2) ? 1 : $clog2(FILT + 1);

  logic [1:0]    sync_q;
  logic          flt_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      flt_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != flt_q) begin
        if (cnt_q == CW'(FILT - 1)) begin
          flt_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign flt_o = flt_q;

  // R5: level only moves after FILT agreeing samples
  p_filter_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_q != $past(flt_q)) |-> ($past(cnt_q) == CW'(FILT - 1)));
endmodule

// File: rtl/pw_capture.sv
module pw_capture #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_f_i,
  input  logic          we_f_i,
  input  logic          oe_f_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          start_o,
  output logic          end_o,
  output logic          act_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);
  logic          both_lo;
  logic          both_q;
  logic          in_wr_q;
  logic [AW-1:0] addr_q;

  assign both_lo = ~cs_f_i & ~we_f_i;
  // opening edge: later of the two strobes falls, output enable high
  assign start_o = both_lo & ~both_q & oe_f_i;
  // closing edge: earlier of the two strobes rises
  assign end_o   = in_wr_q & ~both_lo;
  assign act_o   = in_wr_q | start_o;
  assign addr_o  = addr_q;
  assign data_o  = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      both_q  <= 1'b0;
      in_wr_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      both_q <= both_lo;
      if (start_o) begin
        in_wr_q <= 1'b1;
        addr_q  <= addr_i;
      end else if (end_o) begin
        in_wr_q <= 1'b0;
      end
    end
  end

  p_open_needs_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_wr_q) |-> $past(oe_f_i));

  p_open_needs_both_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_wr_q) |-> ($past(cs_f_i) == 1'b0 && $past(we_f_i) == 1'b0));
endmodule

// File: rtl/pw_nv_array.sv
module pw_nv_array #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R8: cells change only during the programming interval
  p_write_in_prog_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> prog_i);
endmodule

// File: rtl/pw_page_seq.sv
module pw_page_seq
  import pw_pkg::*;
#(
  parameter int unsigned AW       = 10,
  parameter int unsigned PW       = 7,
  parameter int unsigned LOAD_CYC = 15000,
  parameter int unsigned PROG_CYC = 600000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          end_i,
  input  logic          act_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          busy_o,
  output logic          prog_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o,
  output logic          last_vld_o,
  output logic [AW-1:0] last_addr_o,
  output logic [7:0]    last_data_o
);
  localparam int unsigned PAGE = 1 << PW;
  localparam int unsigned IW   = PW + 1;
  localparam int unsigned LCW  = $clog2(LOAD_CYC + 1);
  localparam int unsigned PCW  = $clog2(PROG_CYC + 1);

  seq_state_e       state_q;
  logic             armed_q;
  logic             first_q;
  logic [LCW-1:0]   ld_cnt_q;
  logic [PCW-1:0]   pcnt_q;
  logic [IW-1:0]    idx_q;
  logic [PAGE-1:0]  vld_q;
  logic [AW-PW-1:0] page_q;
  logic             last_vld_q;
  logic [AW-1:0]    last_addr_q;
  logic [7:0]       last_data_q;
  logic [7:0]       buf_q [PAGE];

  logic             load_byte;
  logic [PW-1:0]    off;

  assign off       = addr_i[PW-1:0];
  assign load_byte = (state_q == ST_LOAD) && end_i && armed_q;

  always_ff @(posedge clk_i) begin
    if (load_byte) buf_q[off] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      armed_q     <= 1'b0;
      first_q     <= 1'b0;
      ld_cnt_q    <= '0;
      pcnt_q      <= '0;
      idx_q       <= '0;
      vld_q       <= '0;
      page_q      <= '0;
      last_vld_q  <= 1'b0;
      last_addr_q <= '0;
      last_data_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_LOAD;
            armed_q  <= 1'b1;
            first_q  <= 1'b1;
            ld_cnt_q <= '0;
          end
        end
        ST_LOAD: begin
          if (start_i) begin
            armed_q  <= 1'b1;
            ld_cnt_q <= '0;
          end else if (load_byte) begin
            vld_q[off]  <= 1'b1;
            armed_q     <= 1'b0;
            ld_cnt_q    <= '0;
            last_vld_q  <= 1'b1;
            last_addr_q <= addr_i;
            last_data_q <= data_i;
            if (first_q) begin
              page_q  <= addr_i[AW-1:PW];
              first_q <= 1'b0;
            end
          end else if (!act_i) begin
            if (ld_cnt_q == LCW'(LOAD_CYC - 1)) begin
              state_q <= ST_PROG;
              pcnt_q  <= '0;
              idx_q   <= '0;
            end else begin
              ld_cnt_q <= ld_cnt_q + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (idx_q < IW'(PAGE)) idx_q <= idx_q + 1'b1;
          if (pcnt_q == PCW'(PROG_CYC - 1)) begin
            state_q    <= ST_IDLE;
            vld_q      <= '0;
            last_vld_q <= 1'b0;
            armed_q    <= 1'b0;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // one buffered byte per cycle at the start of the interval
  assign mem_we_o    = (state_q == ST_PROG) && (idx_q < IW'(PAGE)) && vld_q[idx_q[PW-1:0]];
  assign mem_addr_o  = {page_q, idx_q[PW-1:0]};
  assign mem_data_o  = buf_q[idx_q[PW-1:0]];
  assign busy_o      = (state_q != ST_IDLE);
  assign prog_o      = (state_q == ST_PROG);
  assign last_vld_o  = last_vld_q;
  assign last_addr_o = last_addr_q;
  assign last_data_o = last_data_q;

  p_busy_on_open_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_busy_ends_prog_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(prog_o));

  p_prog_len_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prog_o) |-> ($past(pcnt_q) == PCW'(PROG_CYC - 1)));

  p_prog_ignores_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |=> (!prog_o || $stable(vld_q)));
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
  import pw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned PAGE_W   = 7,
  parameter int unsigned LOAD_CYC = 15000,
  parameter int unsigned PROG_CYC = 600000,
  parameter int unsigned FILT     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o,
  output logic              prog_o
);
  logic [N_STRB-1:0] raw_n;
  logic [N_STRB-1:0] flt_n;

  assign raw_n[STRB_CS] = cs_ni;
  assign raw_n[STRB_WE] = we_ni;
  assign raw_n[STRB_OE] = oe_ni;

  for (genvar g = 0; g < N_STRB; g++) begin : g_strb
    pw_deglitch #(.FILT(FILT)) u_dg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (raw_n[g]),
      .flt_o (flt_n[g])
    );
  end

  logic              start, wend, act;
  logic [ADDR_W-1:0] cap_addr;
  logic [7:0]        cap_data;

  pw_capture #(.AW(ADDR_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_f_i (flt_n[STRB_CS]),
    .we_f_i (flt_n[STRB_WE]),
    .oe_f_i (flt_n[STRB_OE]),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .start_o(start),
    .end_o  (wend),
    .act_o  (act),
    .addr_o (cap_addr),
    .data_o (cap_data)
  );

  logic              mem_we, last_vld, busy, prog;
  logic [ADDR_W-1:0] mem_addr, last_addr;
  logic [7:0]        mem_data, last_data, arr_rd;

  pw_page_seq #(
    .AW      (ADDR_W),
    .PW      (PAGE_W),
    .LOAD_CYC(LOAD_CYC),
    .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .end_i      (wend),
    .act_i      (act),
    .addr_i     (cap_addr),
    .data_i     (cap_data),
    .busy_o     (busy),
    .prog_o     (prog),
    .mem_we_o   (mem_we),
    .mem_addr_o (mem_addr),
    .mem_data_o (mem_data),
    .last_vld_o (last_vld),
    .last_addr_o(last_addr),
    .last_data_o(last_data)
  );

  pw_nv_array #(.AW(ADDR_W)) u_arr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .prog_i (prog),
    .we_i   (mem_we),
    .waddr_i(mem_addr),
    .wdata_i(mem_data),
    .raddr_i(addr_i),
    .rdata_o(arr_rd)
  );

  logic rd_en, poll_hit;
  assign rd_en    = ~cs_ni & ~oe_ni & we_ni;
  assign poll_hit = busy & last_vld & (addr_i == last_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (!rd_en)   rdata_o <= '0;
    else if (poll_hit) rdata_o <= {~last_data[7], last_data[6:0]};
    else               rdata_o <= arr_rd;
  end

  assign busy_o = busy;
  assign prog_o = prog;

  p_rd_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o != 8'h00) |-> $past(~cs_ni & ~oe_ni & we_ni));
endmodule

// File: tb/page_write_engine_bench.sv
module page_write_engine_bench;
  localparam int unsigned AW    = 10;
  localparam int unsigned LOADC = 40;
  localparam int unsigned PROGC = 300;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          busy, prog;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  page_write_engine #(
    .ADDR_W(AW), .PAGE_W(7), .LOAD_CYC(LOADC), .PROG_CYC(PROGC), .FILT(3)
  ) u_page_write_engine (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .prog_o(prog)
  );

  // {address, data}: one burst in page 1, last offset of page included
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {10'h080, 8'h12}, {10'h081, 8'h34}, {10'h0A5, 8'h56},
    {10'h0FF, 8'h9A}, {10'h0C0, 8'hBE}, {10'h0B1, 8'hEF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0;
    repeat (8) @(negedge clk); we_n = 1'b1;
    repeat (3) @(negedge clk); cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic rd_byte(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (3) @(negedge clk); d = rdata;
    cs_n = 1'b1; oe_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_prog(output int cyc);
    cyc = 0;
    while (!prog && cyc < 3000) begin @(negedge clk); cyc++; end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 prog", prog, 0);
    rd_byte(10'h005, r);
    chk("R1 erased", r, 8'hFF);
    chk("R2 idle rdata zero", rdata, 0);

    // table burst: R6, R7, R11, R2, R8
    for (int i = 0; i < NV; i++) begin
      wr_byte(VEC[i][17:8], VEC[i][7:0]);
      chk("R6 busy during load", busy, 1);
      chk("R7 no prog while retriggered", prog, 0);
    end
    wait_prog(cyc);
    chk("R7 load timeout window", (cyc >= LOADC - 10 && cyc <= LOADC + 4), 1);
    cyc = 0;
    while (prog && cyc < 2000) begin @(negedge clk); cyc++; end
    chk("R11 prog length", cyc, PROGC);
    chk("R6 busy ends with prog", busy, 0);
    for (int i = 0; i < NV; i++) begin
      rd_byte(VEC[i][17:8], r);
      chk("R2 readback", r, VEC[i][7:0]);
    end
    rd_byte(10'h082, r);
    chk("R8 unloaded byte kept", r, 8'hFF);

    // R8 page from first byte, R10 polling, R9 ignore during prog
    wr_byte(10'h105, 8'h3C);
    wr_byte(10'h20A, 8'h5A);
    rd_byte(10'h20A, r);
    chk("R10 poll inverts bit7", r, 8'hDA);
    wait_prog(cyc);
    chk("R9 prog reached", prog, 1);
    wr_byte(10'h110, 8'h77);
    wait_idle();
    repeat (60) @(negedge clk);
    chk("R9 no new burst", busy, 0);
    rd_byte(10'h110, r);
    chk("R9 ignored byte absent", r, 8'hFF);
    rd_byte(10'h10A, r);
    chk("R8 offset in first page", r, 8'h5A);
    rd_byte(10'h20A, r);
    chk("R8 other page untouched", r, 8'hFF);
    rd_byte(10'h105, r);
    chk("R10 true data when idle", r, 8'h3C);

    // R12 data at close, R13 address at open
    @(negedge clk); addr = 10'h181; wdata = 8'h11; oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0;
    repeat (9) @(negedge clk); addr = 10'h1F0; wdata = 8'hA5;
    repeat (4) @(negedge clk); we_n = 1'b1;
    repeat (3) @(negedge clk); cs_n = 1'b1;
    repeat (5) @(negedge clk);
    wait_idle();
    rd_byte(10'h181, r);
    chk("R12 data at close", r, 8'hA5);
    rd_byte(10'h1F0, r);
    chk("R13 address at open", r, 8'hFF);

    // R3 output enable low blocks
    @(negedge clk); addr = 10'h222; wdata = 8'h00; oe_n = 1'b0;
    repeat (3) @(negedge clk); cs_n = 1'b0; we_n = 1'b0;
    repeat (10) @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
    repeat (6) @(negedge clk); oe_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 busy", busy, 0);
    rd_byte(10'h222, r);
    chk("R3 array", r, 8'hFF);

    // R4 single strobe low
    @(negedge clk); cs_n = 1'b0;
    repeat (12) @(negedge clk); cs_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R4 cs only", busy, 0);
    @(negedge clk); we_n = 1'b0;
    repeat (12) @(negedge clk); we_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R4 we only", busy, 0);

    // R5 short pulse
    @(negedge clk); addr = 10'h233; wdata = 8'h00; cs_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R5 short pulse", busy, 0);
    rd_byte(10'h233, r);
    chk("R5 array", r, 8'hFF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule